// File: doc/BRIEF.md
# Low-Power Channel Handshake Sequencer

This block runs the requesting side of a four-wire low-power channel handshake toward a subsystem. The request is an output. Accept, deny and active come back as inputs. A one-cycle command pulse starts one of two operations: bring the channel up (enable) or take it down (disable). The block reports the end of each operation with a one-cycle done pulse and a set of sticky error flags.

**Enable.** The sequencer first takes the external power controller out of bypass. It then forces the bus clock on and waits for the clock-off status to clear. Only after that does it raise the request and wait for accept.

**Disable.** The sequencer waits, for a bounded time, for the channel to go idle. It then drops the request and samples the response:
- A deny makes it re-raise the request and start a new attempt.
- A released accept ends the operation successfully.

Both the attempts and the samples within an attempt are bounded.

**Timing.** All waits sample their inputs on a fixed poll interval. The interval is `CYC_PER_US * POLL_US` clock cycles, which is 40 cycles at the default values.

Top module: `lp_chan_seq`

## Requirements
- R1: After reset, the outputs are: `chanReq`=0, `forceClkOn`=0, `pwrCtlBypass`=1, `done`=0, `busy`=0 and all three error flags 0.
- R2: While `featureEn`=0, an accepted command completes as a no-op. `done` is high in the cycle right after the accepting edge, and `chanReq`, `forceClkOn` and `pwrCtlBypass` do not change.
- R3: An enable command (`cmdDisable`=0) drives `pwrCtlBypass` to 0 and `forceClkOn` to 1 in the cycle after acceptance. `chanReq` stays 0 until a sample sees `clkOff`=0, and it rises on that sample.
- R4: Every wait samples its inputs once per poll interval of 40 cycles, starting 40 cycles after the wait begins. An enable whose first clock sample and first accept sample both succeed reports `done` 80 cycles after acceptance, with `chanReq`=1.
- R5: If accept stays 0 for 10 accept samples, the enable ends with `errEnTimeout`=1 and `done`. This is 440 cycles after acceptance when the clock was already running.
- R6: If `clkOff` stays 1 for 10 clock samples, the enable ends with `errClkTimeout`=1 and `done` 400 cycles after acceptance, and `chanReq` is never raised.
- R7: A disable command (`cmdDisable`=1) waits for `chanActive`=0 for at most 10 samples. It then drops `chanReq` whether or not active cleared; a timeout here sets no error.
- R8: After the request drops, each sample checks deny before accept. Deny=1 re-raises `chanReq` and starts a new attempt with a fresh wait for idle.
- R9: A sample with deny=0 and accept=0 ends the disable successfully, with `chanReq`=0 and no error flag.
- R10: Ten samples after the drop with accept=1 and deny=0 end the disable with `errTakedown`=1. No further attempt is made.
- R11: A disable makes at most 10 attempts. If every attempt is denied, it ends with `errTakedown`=1 and `chanReq`=1, 800 cycles after acceptance when active is already 0.
- R12: `done` is a single-cycle pulse. The error flags hold until the next accepted command clears them. A command arriving while `busy`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| featureEn | input | 1 | Channel handling enabled; 0 turns every command into a no-op |
| cmdValid | input | 1 | One-cycle command strobe, taken only when idle |
| cmdDisable | input | 1 | Command kind: 0 enable, 1 disable |
| clkOff | input | 1 | Bus clock-off status, 1 while the clock is stopped |
| chanAccept | input | 1 | Channel accept response |
| chanDeny | input | 1 | Channel deny response |
| chanActive | input | 1 | Channel activity indication |
| chanReq | output | 1 | Channel request |
| forceClkOn | output | 1 | Forces the bus clock on |
| pwrCtlBypass | output | 1 | External power controller bypass, cleared before an enable |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| errEnTimeout | output | 1 | Sticky: accept never seen during enable |
| errClkTimeout | output | 1 | Sticky: bus clock never started |
| errTakedown | output | 1 | Sticky: disable did not complete |

## Verification
The bench targets the points where the retry structure could collapse:
- **Deny priority.** A deny arriving together with a released accept must count as a deny. A design that checked accept first would finish after one attempt, 80 cycles after acceptance, instead of retrying.
- **Inner budget.** When accept stays high without a deny, the disable must stop after one attempt. A design that chained this case into the outer retries would report much later than 440 cycles.
- **Outer retries.** Under repeated denies the completion must land at exactly 800 cycles, with the request left high. This catches off-by-one attempt counts.
- **Active timeout.** A stuck active signal must still lead to the request drop and a clean success.

Further checks cover:
- a command injected mid-operation, which must not disturb the running sequence;
- clearing of the sticky flags by the next command;
- the single-cycle width of `done`.

// File: rtl/lp_chan_seq_pkg.sv
package lp_chan_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLK_WAIT,
    ST_ACC_WAIT,
    ST_ACT_WAIT,
    ST_DROP_WAIT
  } seqState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic restartWait;
    logic useClkLimit;
    logic clrOuter;
    logic incOuter;
    logic setReq;
    logic clrReq;
    logic forceClk;
    logic clrErrs;
    logic setErrEn;
    logic setErrClk;
    logic setErrTd;
    logic pulseDone;
  } seqStrobe_t;

endpackage

// File: rtl/lp_chan_seq_dp.sv
module lp_chan_seq_dp
  import lp_chan_seq_pkg::*;
#(
  parameter int CYC_PER_US  = 8,
  parameter int POLL_US     = 5,
  parameter int POLL_LIMIT  = 10,
  parameter int CLK_LIMIT   = 10,
  parameter int OUTER_TRIES = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  output logic       sampleTick,
  output logic       lastSample,
  output logic       lastOuter,
  output logic       chanReq,
  output logic       forceClkOn,
  output logic       pwrCtlBypass,
  output logic       done,
  output logic       errEnTimeout,
  output logic       errClkTimeout,
  output logic       errTakedown
);

  localparam int POLL_CYC = CYC_PER_US * POLL_US;
  localparam int CYC_W    = $clog2(POLL_CYC + 1);
  localparam int SAMP_MAX = (POLL_LIMIT > CLK_LIMIT) ? POLL_LIMIT : CLK_LIMIT;
  localparam int SAMP_W   = $clog2(SAMP_MAX + 1);
  localparam int OUT_W    = $clog2(OUTER_TRIES + 1);

  logic [CYC_W-1:0]  pollCyc;
  logic [SAMP_W-1:0] sampleCnt;
  logic [OUT_W-1:0]  outerCnt;
  logic              limSel;

  assign sampleTick = (pollCyc == CYC_W'(POLL_CYC - 1));
  assign lastSample = sampleTick &&
    (sampleCnt == (limSel ? SAMP_W'(CLK_LIMIT - 1) : SAMP_W'(POLL_LIMIT - 1)));
  assign lastOuter  = (outerCnt == OUT_W'(OUTER_TRIES - 1));

  // poll interval timer and per-wait sample counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCyc   <= '0;
      sampleCnt <= '0;
      limSel    <= 1'b0;
    end else if (stb.restartWait) begin
      pollCyc   <= '0;
      sampleCnt <= '0;
      limSel    <= stb.useClkLimit;
    end else if (sampleTick) begin
      pollCyc   <= '0;
      sampleCnt <= sampleCnt + SAMP_W'(1);
    end else begin
      pollCyc   <= pollCyc + CYC_W'(1);
    end
  end

  // takedown attempt counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outerCnt <= '0;
    else if (stb.clrOuter) outerCnt <= '0;
    else if (stb.incOuter) outerCnt <= outerCnt + OUT_W'(1);
  end

  // channel and clock controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReq      <= 1'b0;
      forceClkOn   <= 1'b0;
      pwrCtlBypass <= 1'b1;
      done         <= 1'b0;
    end else begin
      if (stb.setReq)      chanReq <= 1'b1;
      else if (stb.clrReq) chanReq <= 1'b0;
      if (stb.forceClk) begin
        forceClkOn   <= 1'b1;
        pwrCtlBypass <= 1'b0;
      end
      done <= stb.pulseDone;
    end
  end

  // sticky error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errEnTimeout  <= 1'b0;
      errClkTimeout <= 1'b0;
      errTakedown   <= 1'b0;
    end else if (stb.clrErrs) begin
      errEnTimeout  <= 1'b0;
      errClkTimeout <= 1'b0;
      errTakedown   <= 1'b0;
    end else begin
      if (stb.setErrEn)  errEnTimeout  <= 1'b1;
      if (stb.setErrClk) errClkTimeout <= 1'b1;
      if (stb.setErrTd)  errTakedown   <= 1'b1;
    end
  end

endmodule

// File: rtl/lp_chan_seq_ctrl.sv
module lp_chan_seq_ctrl
  import lp_chan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       featureEn,
  input  logic       cmdValid,
  input  logic       cmdDisable,
  input  logic       clkOff,
  input  logic       chanAccept,
  input  logic       chanDeny,
  input  logic       chanActive,
  input  logic       sampleTick,
  input  logic       lastSample,
  input  logic       lastOuter,
  output seqStrobe_t stb,
  output logic       busy
);

  seqState_t st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  assign busy = (st != ST_IDLE);

  always_comb begin
    stb = '0;
    nxt = st;
    unique case (st)
      ST_IDLE: begin
        if (cmdValid) begin
          stb.clrErrs = 1'b1;
          if (!featureEn) begin
            stb.pulseDone = 1'b1;
          end else if (!cmdDisable) begin
            stb.forceClk    = 1'b1;
            stb.restartWait = 1'b1;
            stb.useClkLimit = 1'b1;
            nxt             = ST_CLK_WAIT;
          end else begin
            stb.restartWait = 1'b1;
            stb.clrOuter    = 1'b1;
            nxt             = ST_ACT_WAIT;
          end
        end
      end
      ST_CLK_WAIT: begin
        if (sampleTick) begin
          if (!clkOff) begin
            stb.setReq      = 1'b1;
            stb.restartWait = 1'b1;
            nxt             = ST_ACC_WAIT;
          end else if (lastSample) begin
            stb.setErrClk = 1'b1;
            stb.pulseDone = 1'b1;
            nxt           = ST_IDLE;
          end
        end
      end
      ST_ACC_WAIT: begin
        if (sampleTick) begin
          if (chanAccept) begin
            stb.pulseDone = 1'b1;
            nxt           = ST_IDLE;
          end else if (lastSample) begin
            stb.setErrEn  = 1'b1;
            stb.pulseDone = 1'b1;
            nxt           = ST_IDLE;
          end
        end
      end
      ST_ACT_WAIT: begin
        // a timeout on idle does not abort: the request drops anyway
        if (sampleTick && (!chanActive || lastSample)) begin
          stb.clrReq      = 1'b1;
          stb.restartWait = 1'b1;
          nxt             = ST_DROP_WAIT;
        end
      end
      ST_DROP_WAIT: begin
        if (sampleTick) begin
          if (chanDeny) begin
            stb.setReq = 1'b1;
            if (lastOuter) begin
              stb.setErrTd  = 1'b1;
              stb.pulseDone = 1'b1;
              nxt           = ST_IDLE;
            end else begin
              stb.incOuter    = 1'b1;
              stb.restartWait = 1'b1;
              nxt             = ST_ACT_WAIT;
            end
          end else if (!chanAccept) begin
            stb.pulseDone = 1'b1;
            nxt           = ST_IDLE;
          end else if (lastSample) begin
            stb.setErrTd  = 1'b1;
            stb.pulseDone = 1'b1;
            nxt           = ST_IDLE;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lp_chan_seq.sv
module lp_chan_seq
  import lp_chan_seq_pkg::*;
#(
  parameter int CYC_PER_US  = 8,
  parameter int POLL_US     = 5,
  parameter int POLL_LIMIT  = 10,
  parameter int CLK_LIMIT   = 10,
  parameter int OUTER_TRIES = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic featureEn,
  input  logic cmdValid,
  input  logic cmdDisable,
  input  logic clkOff,
  input  logic chanAccept,
  input  logic chanDeny,
  input  logic chanActive,
  output logic chanReq,
  output logic forceClkOn,
  output logic pwrCtlBypass,
  output logic busy,
  output logic done,
  output logic errEnTimeout,
  output logic errClkTimeout,
  output logic errTakedown
);

  seqStrobe_t stb;
  logic       sampleTick;
  logic       lastSample;
  logic       lastOuter;

  lp_chan_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .featureEn  (featureEn),
    .cmdValid   (cmdValid),
    .cmdDisable (cmdDisable),
    .clkOff     (clkOff),
    .chanAccept (chanAccept),
    .chanDeny   (chanDeny),
    .chanActive (chanActive),
    .sampleTick (sampleTick),
    .lastSample (lastSample),
    .lastOuter  (lastOuter),
    .stb        (stb),
    .busy       (busy)
  );

  lp_chan_seq_dp #(
    .CYC_PER_US  (CYC_PER_US),
    .POLL_US     (POLL_US),
    .POLL_LIMIT  (POLL_LIMIT),
    .CLK_LIMIT   (CLK_LIMIT),
    .OUTER_TRIES (OUTER_TRIES)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .sampleTick    (sampleTick),
    .lastSample    (lastSample),
    .lastOuter     (lastOuter),
    .chanReq       (chanReq),
    .forceClkOn    (forceClkOn),
    .pwrCtlBypass  (pwrCtlBypass),
    .done          (done),
    .errEnTimeout  (errEnTimeout),
    .errClkTimeout (errClkTimeout),
    .errTakedown   (errTakedown)
  );

endmodule

// File: rtl/lp_chan_seq_chk.sv
module lp_chan_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic busy,
  input logic done,
  input logic chanReq,
  input logic errEnTimeout,
  input logic errClkTimeout,
  input logic errTakedown
);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_errs_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> (!errEnTimeout && !errClkTimeout && !errTakedown));

  p_idle_req_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdValid) |=> $stable(chanReq));

  p_req_rise_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanReq) |-> $past(busy));

  p_en_err_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errEnTimeout) |-> done);

  p_clk_err_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errClkTimeout) |-> done);

  p_td_err_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTakedown) |-> done);

endmodule

bind lp_chan_seq lp_chan_seq_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .cmdValid      (cmdValid),
  .busy          (busy),
  .done          (done),
  .chanReq       (chanReq),
  .errEnTimeout  (errEnTimeout),
  .errClkTimeout (errClkTimeout),
  .errTakedown   (errTakedown)
);

// File: tb/lp_chan_seq_tb_top.sv
module lp_chan_seq_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic featureEn = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdDisable = 1'b0;
  logic clkOff = 1'b1;
  logic chanAccept = 1'b0;
  logic chanActive = 1'b0;
  logic chanDeny;
  logic chanReq, forceClkOn, pwrCtlBypass, busy, done;
  logic errEnTimeout, errClkTimeout, errTakedown;

  int testsRun = 0;
  int testsFailed = 0;
  int denyLeft = 0;
  logic prevReq = 1'b0;
  logic earlyForce, earlyBypass, earlyReq, doneAfter;

  always #4 clk = ~clk;

  assign chanDeny = (denyLeft > 0);

  // bench responder: each re-raise of the request consumes one deny
  always @(posedge clk) begin
    if (chanReq && !prevReq && denyLeft > 0) denyLeft <= denyLeft - 1;
    prevReq <= chanReq;
  end

  lp_chan_seq dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .featureEn     (featureEn),
    .cmdValid      (cmdValid),
    .cmdDisable    (cmdDisable),
    .clkOff        (clkOff),
    .chanAccept    (chanAccept),
    .chanDeny      (chanDeny),
    .chanActive    (chanActive),
    .chanReq       (chanReq),
    .forceClkOn    (forceClkOn),
    .pwrCtlBypass  (pwrCtlBypass),
    .busy          (busy),
    .done          (done),
    .errEnTimeout  (errEnTimeout),
    .errClkTimeout (errClkTimeout),
    .errTakedown   (errTakedown)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue a command, return cycles from accepting edge to done; optionally
  // inject a second command at cycle injectAt
  task automatic runCmd(input logic dis, input int injectAt, output int n);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdDisable = dis;
    @(negedge clk);
    cmdValid = 1'b0;
    n = 0;
    earlyForce = forceClkOn;
    earlyBypass = pwrCtlBypass;
    earlyReq = chanReq;
    while (!done && n < 5000) begin
      if (n == injectAt) begin
        cmdValid = 1'b1;
        cmdDisable = ~dis;
      end
      @(negedge clk);
      cmdValid = 1'b0;
      n++;
    end
    @(negedge clk);
    doneAfter = done;
  endtask

  task automatic testReset();
    check("R1 chanReq", chanReq, 0);
    check("R1 forceClkOn", forceClkOn, 0);
    check("R1 pwrCtlBypass", pwrCtlBypass, 1);
    check("R1 done/busy", {done, busy}, 0);
    check("R1 errors", {errEnTimeout, errClkTimeout, errTakedown}, 0);
  endtask

  task automatic testNoop();
    int n;
    featureEn = 1'b0;
    runCmd(1'b0, -1, n);
    check("R2 noop enable latency", n, 0);
    check("R2 noop outputs", {chanReq, forceClkOn, pwrCtlBypass}, 3'b001);
    check("R12 done single cycle", doneAfter, 0);
    runCmd(1'b1, -1, n);
    check("R2 noop disable latency", n, 0);
  endtask

  task automatic testClkTimeout();
    int n;
    featureEn = 1'b1;
    clkOff = 1'b1;
    runCmd(1'b0, -1, n);
    check("R3 force/bypass early", {earlyForce, earlyBypass}, 2'b10);
    check("R3 req held before clock", earlyReq, 0);
    check("R6 clock timeout latency", n, 400);
    check("R6 clock error", errClkTimeout, 1);
    check("R6 no request", chanReq, 0);
  endtask

  task automatic testEnableOk();
    int n;
    clkOff = 1'b0;
    chanAccept = 1'b1;
    runCmd(1'b0, -1, n);
    check("R4 enable latency", n, 80);
    check("R4 request up", chanReq, 1);
    check("R12 errors cleared", {errEnTimeout, errClkTimeout, errTakedown}, 0);
  endtask

  task automatic testDisableOk();
    int n;
    chanAccept = 1'b0;
    chanActive = 1'b0;
    runCmd(1'b1, -1, n);
    check("R9 disable latency", n, 80);
    check("R9 request down", chanReq, 0);
    check("R9 no error", errTakedown, 0);
  endtask

  task automatic testEnableTimeoutBusy();
    int n;
    chanAccept = 1'b0;
    runCmd(1'b0, 100, n);
    check("R5 enable timeout latency (R12 busy ignore)", n, 440);
    check("R5 enable error", errEnTimeout, 1);
    check("R12 request kept", chanReq, 1);
  endtask

  task automatic testActiveStuck();
    int n;
    chanActive = 1'b1;
    chanAccept = 1'b0;
    runCmd(1'b1, -1, n);
    check("R7 active timeout latency", n, 440);
    check("R7 request dropped", chanReq, 0);
    check("R7 no error", {errEnTimeout, errTakedown}, 0);
    chanActive = 1'b0;
  endtask

  task automatic testInnerBudget();
    int n;
    chanAccept = 1'b1;
    runCmd(1'b0, -1, n);
    check("R4 re-enable", n, 80);
    runCmd(1'b1, -1, n);
    check("R10 inner budget latency", n, 440);
    check("R10 takedown error", errTakedown, 1);
    check("R10 request low", chanReq, 0);
  endtask

  task automatic testDenyRetry();
    int n;
    chanAccept = 1'b1;
    runCmd(1'b0, -1, n);
    chanAccept = 1'b0;
    denyLeft = 2;
    runCmd(1'b1, -1, n);
    check("R8 deny retry latency", n, 240);
    check("R8 request down after retries", chanReq, 0);
    check("R8 no error", errTakedown, 0);
  endtask

  task automatic testAlwaysDeny();
    int n;
    chanAccept = 1'b1;
    runCmd(1'b0, -1, n);
    chanAccept = 1'b0;
    denyLeft = 1000;
    runCmd(1'b1, -1, n);
    check("R11 attempt limit latency", n, 800);
    check("R11 takedown error", errTakedown, 1);
    check("R11 request re-raised", chanReq, 1);
    denyLeft = 0;
  endtask

  task automatic testClearOnNoop();
    int n;
    featureEn = 1'b0;
    runCmd(1'b1, -1, n);
    check("R12 errors cleared by noop", errTakedown, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoop();
    testClkTimeout();
    testEnableOk();
    testDisableOk();
    testEnableTimeoutBusy();
    testActiveStuck();
    testInnerBudget();
    testDenyRetry();
    testAlwaysDeny();
    testClearOnNoop();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule